// File: doc/BRIEF.md
# PLL Configuration Register Pair

This block holds the settings a clock generator needs for its phase-locked loop: a frequency multiplier choice, a post-divider choice and an on/off control. The settings live in two adjacent 8-bit registers that software always writes together as one 16-bit word. The block decodes the stored settings into plain ratio outputs that the clock generator uses directly.

Every write passes through a set of gates. First, a protect-open input must be high. Second, a clock-change lock input must be low. Third, the multiplier and divider fields can change only while the loop is off. In addition, the multiplier field accepts a legal code only once after reset. A write whose multiplier code is not legal leaves the field as it was and raises an error strobe for one cycle. The block does not contain the loop itself, the clock switching or any low-power sequencing.

Top module: `pll_cfg_regs`

## Requirements
- R1: After reset, `rdata` reads 16'h0012, `pll_on` is 0, `mult_ratio` is 0, `div_ratio` is 2 and `cfg_err` is 0.
- R2: The multiplier code is word bits [2:0]. Code 3'b011 gives `mult_ratio` 6 and code 3'b100 gives 8. Any other stored code, including the reset code 3'b010, gives `mult_ratio` 0.
- R3: If an accepted multiplier write carries a code other than 3'b011 or 3'b100, the stored code stays as it was and `cfg_err` is 1 for exactly the cycle after the write.
- R4: A write made while `wp_open` is 0 changes no register bit.
- R5: A write made while `clk_lock` is 1 changes no register bit and raises no error.
- R6: Once a legal multiplier code has been stored, later writes do not change it until the next reset.
- R7: The divider select is word bit 10, where 0 gives `div_ratio` 2 and 1 gives 3. It changes only if the loop was off before the write.
- R8: The loop enable is word bit 7 and drives `pll_on`. If a write turns the loop on, the multiplier and divider fields carried in that same write are stored in that same write.
- R9: Reserved bits ignore writes. Word bits [7:0] read as {enable, 3'b001, 1'b0, code}, and word bits [15:8] read as {5'b00000, divider, 2'b00}.
- R10: A write that is let through by protect and lock can turn the loop off at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Strobe for a 16-bit write |
| wdata | input | 16 | Write word; the low register is in [7:0] and the high register is in [15:8] |
| wp_open | input | 1 | Protect-open; when it is 1, writes may reach the registers |
| clk_lock | input | 1 | Clock-change lock; when it is 1, all writes are dropped |
| rdata | output | 16 | Readback of both registers |
| mult_ratio | output | 4 | Decoded multiplier (6, 8, or 0 when unset) |
| div_ratio | output | 2 | Decoded divider (2 or 3) |
| pll_on | output | 1 | Loop enable |
| cfg_err | output | 1 | One-cycle strobe for a rejected multiplier code |

## Verification
A wrong gate decision or a corrupted write-once flag appears at `rdata` and the ratio outputs in the first cycle after the offending write. The sweep therefore resets, writes once, and compares the full readback word and every decoded output on the next cycle. This is done for every combination of protect, lock, code, divider and enable. Sequences that follow cover the effects of history: a second multiplier write, a divider write while the loop is on, and turning the loop off. Any stale flag in those sequences shows up within one write.

// File: rtl/pll_cfg_regs.sv
module pll_cfg_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wdata,
  input  logic        wp_open,
  input  logic        clk_lock,
  output logic [15:0] rdata,
  output logic [3:0]  mult_ratio,
  output logic [1:0]  div_ratio,
  output logic        pll_on,
  output logic        cfg_err
);

  localparam logic [2:0] CODE_X6    = 3'b011;
  localparam logic [2:0] CODE_X8    = 3'b100;
  localparam logic [2:0] CODE_RESET = 3'b010;

  logic [2:0] mult_code;
  logic       mult_set;
  logic       div_sel;
  logic       en_q;

  wire        wr_ok    = wr_en && wp_open && !clk_lock;
  wire        cfg_ok   = wr_ok && !en_q;
  wire        mult_try = cfg_ok && !mult_set;
  wire [2:0]  new_code = wdata[2:0];
  wire        legal    = (new_code == CODE_X6) || (new_code == CODE_X8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mult_code <= CODE_RESET;
      mult_set  <= 1'b0;
      div_sel   <= 1'b0;
      en_q      <= 1'b0;
      cfg_err   <= 1'b0;
    end else begin
      cfg_err <= mult_try && !legal;
      if (mult_try && legal) begin
        mult_code <= new_code;
        mult_set  <= 1'b1;
      end
      if (cfg_ok) div_sel <= wdata[10];
      if (wr_ok)  en_q    <= wdata[7];
    end
  end

  assign rdata      = {5'b00000, div_sel, 2'b00, en_q, 3'b001, 1'b0, mult_code};
  assign mult_ratio = (mult_code == CODE_X6) ? 4'd6 :
                      (mult_code == CODE_X8) ? 4'd8 : 4'd0;
  assign div_ratio  = div_sel ? 2'd3 : 2'd2;
  assign pll_on     = en_q;

endmodule

// File: rtl/pll_cfg_regs_chk.sv
module pll_cfg_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        wp_open,
  input logic        clk_lock,
  input logic [15:0] rdata,
  input logic [3:0]  mult_ratio,
  input logic [1:0]  div_ratio,
  input logic        pll_on,
  input logic        cfg_err
);

  a_r4_protect_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_open |=> $stable(rdata));

  a_r5_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
    clk_lock |=> ($stable(rdata) && !cfg_err));

  a_r6_mult_once: assert property (@(posedge clk) disable iff (!rst_n)
    (mult_ratio != 4'd0) |=> $stable(mult_ratio));

  a_r7_div_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    pll_on |=> $stable(div_ratio));

  a_r3_err_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> $past(wr_en));

  a_r2_ratio_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (mult_ratio == 4'd0) || (mult_ratio == 4'd6) || (mult_ratio == 4'd8));

endmodule

bind pll_cfg_regs pll_cfg_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wp_open(wp_open),
  .clk_lock(clk_lock), .rdata(rdata), .mult_ratio(mult_ratio),
  .div_ratio(div_ratio), .pll_on(pll_on), .cfg_err(cfg_err)
);

// File: tb/pll_cfg_regs_bench.sv
module pll_cfg_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wdata = '0;
  logic        wp_open = 1'b0;
  logic        clk_lock = 1'b0;
  logic [15:0] rdata;
  logic [3:0]  mult_ratio;
  logic [1:0]  div_ratio;
  logic        pll_on;
  logic        cfg_err;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  pll_cfg_regs u_pll_cfg_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata),
    .wp_open(wp_open), .clk_lock(clk_lock), .rdata(rdata),
    .mult_ratio(mult_ratio), .div_ratio(div_ratio), .pll_on(pll_on),
    .cfg_err(cfg_err)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // reserved bits driven opposite to their read values (R9)
  function automatic logic [15:0] word(logic [2:0] code, logic d, logic e);
    return {5'b11111, d, 2'b11, e, 3'b110, 1'b1, code};
  endfunction

  task automatic write(logic [15:0] w);
    wdata = w;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] expect_rd(logic [2:0] code, logic d, logic e);
    return {5'b00000, d, 2'b00, e, 3'b001, 1'b0, code};
  endfunction

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    check("R1 rdata", rdata, 16'h0012);
    check("R1 pll_on", pll_on, 0);
    check("R1 mult", mult_ratio, 0);
    check("R1 div", div_ratio, 2);
    check("R1 err", cfg_err, 0);

    for (int wp = 0; wp < 2; wp++)
      for (int lk = 0; lk < 2; lk++)
        for (int c = 0; c < 8; c++)
          for (int d = 0; d < 2; d++)
            for (int e = 0; e < 2; e++) begin
              logic open, lg;
              logic [2:0] ec;
              do_reset();
              wp_open = wp[0];
              clk_lock = lk[0];
              write(word(c[2:0], d[0], e[0]));
              open = wp[0] && !lk[0];
              lg = (c == 3) || (c == 4);
              ec = (open && lg) ? c[2:0] : 3'b010;
              check(open ? "R9 R2 R8 readback" : (lk[0] ? "R5 readback" : "R4 readback"),
                    rdata, expect_rd(ec, open ? d[0] : 1'b0, open ? e[0] : 1'b0));
              check("R2 ratio", mult_ratio, (ec == 3) ? 6 : (ec == 4) ? 8 : 0);
              check("R7 div", div_ratio, (open && d[0]) ? 3 : 2);
              check("R8 on", pll_on, open && e[0]);
              check("R3 err strobe", cfg_err, open && !lg);
              @(negedge clk);
              check("R3 err one cycle", cfg_err, 0);
            end

    wp_open = 1'b1;
    clk_lock = 1'b0;
    do_reset();
    write(word(3'b111, 1'b0, 1'b0));
    check("R3 illegal keeps code", rdata[2:0], 3'b010);
    write(word(3'b011, 1'b1, 1'b0));
    check("R6 first legal", mult_ratio, 6);
    write(word(3'b100, 1'b0, 1'b0));
    check("R6 second ignored", mult_ratio, 6);
    check("R7 div while off", div_ratio, 2);
    check("R6 no err after set", cfg_err, 0);
    write(word(3'b100, 1'b1, 1'b1));
    check("R8 on", pll_on, 1);
    check("R7 div same write", div_ratio, 3);
    write(word(3'b100, 1'b0, 1'b1));
    check("R7 div frozen while on", div_ratio, 3);
    clk_lock = 1'b1;
    write(word(3'b100, 1'b0, 1'b0));
    check("R5 lock keeps on", pll_on, 1);
    clk_lock = 1'b0;
    write(word(3'b100, 1'b0, 1'b0));
    check("R10 turn off", pll_on, 0);
    check("R7 div held during off write", div_ratio, 3);
    write(word(3'b100, 1'b0, 1'b0));
    check("R7 div after off", div_ratio, 2);
    check("R6 still x6", mult_ratio, 6);
    check("R9 final readback", rdata, expect_rd(3'b011, 1'b0, 1'b0));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule